// File: doc/BRIEF.md
# Gated Pulse-Width Measuring Timer

This block is one channel of a bus-attached programmable timer, used to measure how long an external gate input stays low. Software preloads a 16-bit down-counter through an 8-bit register port. While the active-low gate input is low, each rising edge of an external count clock lowers the counter by one. When the gate returns high the channel raises an interrupt flag and, if enabled, its interrupt request. Software then reads the counter and takes the difference from the preload as the elapsed tick count.

Both external inputs pass through a two-stage synchronizer and are edge-detected in the system clock domain. The counter never reloads itself. A measurement continues from whatever value the last one left, and it wraps from zero to all-ones without stopping. The flag clears only through a fixed sequence: a status read that sees the flag set, followed by a read of the counter's high byte. One offset holds two control registers. A select bit in a second control register decides which of the two a write reaches.

Top module: `gpwt_top`

## Requirements
- R1: After reset, the counter reads 0xFFFF, the status register reads 0x00, `irq` is low, and offset 0 reads 0x00.
- R2: While `gate_n_in` is high, edges on `cnt_clk_in` leave the counter value unchanged.
- R3: While `gate_n_in` is low, each rising edge on `cnt_clk_in` lowers the counter by exactly one.
- R4: A low-to-high transition of `gate_n_in` sets status bit 0, the channel flag.
- R5: `irq` is high exactly while the flag is set and interrupt enable (bit 6 of control register 1) is set. Status bit 7 mirrors `irq`.
- R6: The flag clears on a read of the counter high byte (offset 2) only after a status read (offset 1) that saw the flag set. A high-byte read without that earlier status read leaves the flag set.
- R7: After a measurement, the counter is not reloaded. The next measurement continues from the current value.
- R8: The counter is big-endian. A write to offset 2 goes into a holding latch and leaves the counter unchanged. A write to offset 3 loads {latch, written byte} into the counter. A read of offset 2 returns the high byte and captures the low byte, which a later read of offset 3 returns.
- R9: Offset 0 reaches control register 3 while bit 0 of control register 2 (written at offset 1) is 0, which is its reset value. It reaches control register 1 while that bit is 1. Reads and writes of offset 0 follow the same selection.
- R10: The counter wraps from 0x0000 to 0xFFFF on a count edge.
- R11: If a gate rising edge and a flag-clearing high-byte read take effect in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| cnt_clk_in | input | 1 | External count clock, asynchronous |
| gate_n_in | input | 1 | Active-low measurement gate, asynchronous |
| irq | output | 1 | Interrupt request, active high |

## Verification
Two events can land in one clock cycle: the gate's rising edge setting the flag, and a high-byte read clearing it after an armed status read. The bench provokes the collision by counting synchronizer stages. It drives the gate high and issues the high-byte read two falling edges later, so both take effect at the same rising edge. It then judges the outcome through the status byte and `irq`, which must both still show the flag. A further armed status-then-counter read must then clear the flag.

// File: rtl/gpwt_pkg.sv
package gpwt_pkg;

    parameter int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int ADDR_W = 3;

    localparam logic [CNT_W-1:0] CNT_RESET = '1;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTL13     = 3'd0,
        REG_CTL2_STAT = 3'd1,
        REG_CNT_HI    = 3'd2,
        REG_CNT_LO    = 3'd3
    } reg_off_e;

    localparam int CTL1_IE_BIT   = 6;
    localparam int CTL2_SEL_BIT  = 0;
    localparam int STAT_FLAG_BIT = 0;
    localparam int STAT_IRQ_BIT  = DATA_W - 1;

    typedef struct packed {
        logic              cs;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic             load;
        logic [CNT_W-1:0] value;
    } cnt_load_t;

    function automatic logic [DATA_W-1:0] make_status(input logic flag, input logic req);
        logic [DATA_W-1:0] s;
        s = '0;
        s[STAT_FLAG_BIT] = flag;
        s[STAT_IRQ_BIT]  = req;
        return s;
    endfunction

endpackage

// File: rtl/gpwt_sync.sv
module gpwt_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign level = chain[STAGES-1];
endmodule

// File: rtl/gpwt_counter.sv
module gpwt_counter
    import gpwt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cnt_load_t        ld,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)          count <= CNT_RESET;
        else if (ld.load) count <= ld.value;
        else if (dec)     count <= count - 1'b1;
    end

    AST_LOAD_TAKES_PAIR: assert property (@(posedge clk) disable iff (rst)
        ld.load |=> count == $past(ld.value)); // R8

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!ld.load && !dec) |=> $stable(count)); // R2

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (dec && !ld.load) |=> count == CNT_W'($past(count) - 1'b1)); // R3
endmodule

// File: rtl/gpwt_regs.sv
module gpwt_regs
    import gpwt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [CNT_W-1:0]  count,
    input  logic              gate_rise,
    output cnt_load_t         ld,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [DATA_W-1:0] ctl1, ctl3, hi_latch, lo_snap;
    logic              sel_c1, flag, armed;
    logic              rd_stat, rd_hi, wr_c13, wr_c2, wr_hi, wr_lo;

    always_comb begin
        rd_stat = req.cs && !req.we && req.addr == REG_CTL2_STAT;
        rd_hi   = req.cs && !req.we && req.addr == REG_CNT_HI;
        wr_c13  = req.cs &&  req.we && req.addr == REG_CTL13;
        wr_c2   = req.cs &&  req.we && req.addr == REG_CTL2_STAT;
        wr_hi   = req.cs &&  req.we && req.addr == REG_CNT_HI;
        wr_lo   = req.cs &&  req.we && req.addr == REG_CNT_LO;
    end

    assign ld.load  = wr_lo;
    assign ld.value = {hi_latch, req.wdata};
    assign irq      = flag && ctl1[CTL1_IE_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl1     <= '0;
            ctl3     <= '0;
            sel_c1   <= 1'b0;
            hi_latch <= '1;
            lo_snap  <= '1;
            flag     <= 1'b0;
            armed    <= 1'b0;
        end else begin
            if (wr_c13 &&  sel_c1) ctl1 <= req.wdata;
            if (wr_c13 && !sel_c1) ctl3 <= req.wdata;
            if (wr_c2)             sel_c1 <= req.wdata[CTL2_SEL_BIT];
            if (wr_hi)             hi_latch <= req.wdata;
            if (rd_hi)             lo_snap <= count[DATA_W-1:0];

            if (gate_rise)               flag <= 1'b1;
            else if (rd_hi && armed)     flag <= 1'b0;

            if (rd_stat && flag)         armed <= 1'b1;
            else if (rd_hi)              armed <= 1'b0;
        end
    end

    always_comb begin
        case (req.addr)
            REG_CTL13:     rdata = sel_c1 ? ctl1 : ctl3;
            REG_CTL2_STAT: rdata = make_status(flag, irq);
            REG_CNT_HI:    rdata = count[CNT_W-1:DATA_W];
            REG_CNT_LO:    rdata = lo_snap;
            default:       rdata = '0;
        endcase
    end

    AST_GATE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        gate_rise |=> flag); // R4

    AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> ($past(rd_hi) && $past(armed))); // R6

    AST_REQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag); // R5

    AST_SHARED_CTL_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (wr_c13 && !sel_c1) |=> $stable(ctl1)); // R9

    AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (gate_rise && rd_hi && armed) |=> flag); // R11
endmodule

// File: rtl/gpwt_top.sv
module gpwt_top
    import gpwt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cnt_clk_in,
    input  logic              gate_n_in,
    output logic              irq
);
    logic             clk_lvl, clk_prev, gate_lvl, gate_prev;
    logic             clk_rise, gate_rise, dec;
    logic [CNT_W-1:0] count;
    cnt_load_t        ld;
    bus_req_t         req;

    assign req = '{cs: bus_cs, we: bus_we, addr: bus_addr, wdata: bus_wdata};

    gpwt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_clk_sync (
        .clk(clk), .rst(rst), .din(cnt_clk_in), .level(clk_lvl));

    gpwt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_gate_sync (
        .clk(clk), .rst(rst), .din(gate_n_in), .level(gate_lvl));

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_prev  <= 1'b0;
            gate_prev <= 1'b1;
        end else begin
            clk_prev  <= clk_lvl;
            gate_prev <= gate_lvl;
        end
    end

    assign clk_rise  = clk_lvl && !clk_prev;
    assign gate_rise = gate_lvl && !gate_prev;
    assign dec       = clk_rise && !gate_lvl;

    gpwt_counter u_counter (
        .clk(clk), .rst(rst), .ld(ld), .dec(dec), .count(count));

    gpwt_regs u_regs (
        .clk(clk), .rst(rst), .req(req), .count(count), .gate_rise(gate_rise),
        .ld(ld), .rdata(bus_rdata), .irq(irq));
endmodule

// File: tb/gpwt_top_tb_top.sv
module gpwt_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_cs = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       cnt_clk_in = 1'b0, gate_n_in = 1'b1, irq;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    typedef struct { string tag; logic [7:0] exp; } exp_item_t;
    exp_item_t exp_q[$];

    always #2.5 clk = ~clk;

    gpwt_top dut_i (
        .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_clk_in(cnt_clk_in),
        .gate_n_in(gate_n_in), .irq(irq));

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard for every read, sampled mid-cycle
    always @(negedge clk) begin
        #1;
        if (bus_cs && !bus_we) begin
            if (exp_q.size() == 0) check("scoreboard-empty", 8'h00, 8'h01);
            else begin
                exp_item_t it;
                it = exp_q.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        exp_item_t it;
        it.tag = tag; it.exp = e;
        exp_q.push_back(it);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_cs = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        #1;
        check(tag, {7'd0, irq}, {7'd0, e});
        @(negedge clk);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            cnt_clk_in = 1'b1; repeat (3) @(negedge clk);
            cnt_clk_in = 1'b0; repeat (3) @(negedge clk);
        end
    endtask

    task automatic gate(input logic v);
        gate_n_in = v;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(3'd2, 8'hFF, "R1 cnt hi");
        rd(3'd3, 8'hFF, "R1 cnt lo");
        rd(3'd1, 8'h00, "R1 status");
        rd(3'd0, 8'h00, "R1 ctl");
        chk_irq(1'b0, "R1 irq");
        // R9 offset 0 reaches control 3 after reset
        wr(3'd0, 8'h40);
        rd(3'd0, 8'h40, "R9 ctl3 selected");
        wr(3'd1, 8'h01);
        rd(3'd0, 8'h00, "R9 ctl1 untouched");
        wr(3'd1, 8'h00);
        // R8 big-endian load
        wr(3'd2, 8'h12);
        rd(3'd2, 8'hFF, "R8 hi write held in latch");
        wr(3'd3, 8'h34);
        rd(3'd2, 8'h12, "R8 hi after lo write");
        rd(3'd3, 8'h34, "R8 lo snapshot");
        // R2 gate high blocks counting
        pulse(5);
        rd(3'd2, 8'h12, "R2 hi unchanged");
        rd(3'd3, 8'h34, "R2 lo unchanged");
        // R3/R4 measurement, interrupts disabled
        gate(1'b0);
        pulse(3);
        gate(1'b1);
        rd(3'd1, 8'h01, "R4 flag set");
        chk_irq(1'b0, "R5 irq masked");
        rd(3'd2, 8'h12, "R3 hi");
        rd(3'd3, 8'h31, "R3 three steps");
        rd(3'd1, 8'h00, "R6 cleared by sequence");
        // R9 select control 1, enable interrupt
        wr(3'd1, 8'h01);
        wr(3'd0, 8'h40);
        rd(3'd0, 8'h40, "R9 ctl1 written");
        // R7 no reload
        gate(1'b0);
        pulse(2);
        gate(1'b1);
        chk_irq(1'b1, "R5 irq raised");
        rd(3'd2, 8'h12, "R7 hi continues");
        rd(3'd3, 8'h2F, "R7 lo continues");
        rd(3'd1, 8'h81, "R6 unarmed read kept flag");
        rd(3'd2, 8'h12, "R6 armed hi read");
        chk_irq(1'b0, "R6 irq cleared");
        rd(3'd1, 8'h00, "R6 status cleared");
        // R10 wrap
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h01);
        gate(1'b0);
        pulse(3);
        gate(1'b1);
        rd(3'd2, 8'hFF, "R10 wrap hi");
        rd(3'd3, 8'hFE, "R10 wrap lo");
        rd(3'd1, 8'h81, "R10 flag");
        // R11 collision: flag set, armed; new rise meets clearing read
        gate(1'b0);
        pulse(1);
        gate_n_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(3'd2, 8'hFF, "R11 colliding hi read");
        rd(3'd3, 8'hFD, "R11 lo");
        rd(3'd1, 8'h81, "R11 flag survives");
        chk_irq(1'b1, "R11 irq stays");
        rd(3'd2, 8'hFF, "R11 re-arm hi");
        rd(3'd1, 8'h00, "R11 later clear");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("scoreboard-leftover", 8'h01, 8'h00);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule